// File: doc/BRIEF.md
# H-Bridge Motor PWM Generator

This block produces the four gate-drive levels of a full H-bridge that powers a brushed DC motor. The bridge has a left leg and a right leg, and each leg has a high-side and a low-side switch. The block runs a single up-counting carrier. It feeds that carrier's PWM wave to the high-side switch of one leg while holding the low-side switch of the opposite leg on, so current flows through one diagonal of the bridge. The remaining two switches are held off.

The carrier period is the maximum period scaled by a Q15 fraction. The compare point is that period scaled by a Q15 duty operand. A polarity select chooses whether the duty command is used directly or subtracted from Q15 full scale (0x7FFF). A two-bit rotation command picks the conducting diagonal or turns the bridge off. Period, compare and rotation are captured into shadow registers only when the counter restarts from zero, so a command never cuts a carrier cycle short.

Top module: `hbridge_pwm`

## Requirements
- R1: The effective period P is (periodMax × periodScale) >> 15, taken as 16-bit unsigned. The counter counts 0, 1, …, P and then returns to 0, so one carrier cycle lasts P+1 clock cycles.
- R2: When activeHigh is 1, the duty operand is 0x7FFF − dutyCmd (16-bit unsigned). When activeHigh is 0, the duty operand is dutyCmd unchanged.
- R3: The compare value is C = (P × duty operand) >> 15. The PWM wave is low while the counter is below C and high from count C through count P. With 0 < C ≤ P it is high for P−C+1 cycles of each P+1.
- R4: Rotation code 0 puts the PWM on leftHigh, holds rightLow at 1, and holds leftLow and rightHigh at 0.
- R5: Rotation code 1 puts the PWM on rightHigh, holds leftLow at 1, and holds rightHigh's partner rightLow and leftHigh at 0.
- R6: Rotation codes 2 and 3 hold all four outputs at 0.
- R7: Changes to periodMax, periodScale, dutyCmd, activeHigh or rotation take effect only at the clock edge where the counter returns to 0. Until then, the outputs follow the previously captured values.
- R8: While rst (active high, synchronous) is sampled high, all four outputs are 0 and the counter is cleared. After release, the first counter value is 0, and the PWM output rises at the clock edge on which the counter reaches C.
- R9: A compare value of 0 or greater than P keeps the PWM output steadily low with no edges. The statically held outputs still follow R4 and R5.
- R10: leftHigh and leftLow are never 1 together, and rightHigh and rightLow are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodMax | input | 16 | Maximum carrier period in counts |
| periodScale | input | 16 | Q15 period scale factor |
| dutyCmd | input | 16 | Q15 duty command |
| activeHigh | input | 1 | Duty polarity select (1: subtract from 0x7FFF) |
| rotation | input | 2 | 0: left-high PWM / right-low on; 1: right-high PWM / left-low on; 2,3: off |
| leftHigh | output | 1 | Left leg high-side gate |
| leftLow | output | 1 | Left leg low-side gate |
| rightHigh | output | 1 | Right leg high-side gate |
| rightLow | output | 1 | Right leg low-side gate |

## Verification
The hardest case to reach from the ports is a command change arriving mid-cycle: only internal shadow registers hold the old value, and the counter phase is not visible. The bench finds the cycle start by watching for the PWM falling edge, since that edge marks count zero. It then flips the rotation a known number of cycles later, checks that the old diagonal persists until the counter would wrap, and checks that the new diagonal appears afterwards. The compare boundaries (C = 0, C = P, and C > P reached through a duty command above Q15 full scale) are measured as high-cycle counts over exactly one carrier window, so phase alignment does not matter.

// File: rtl/hbridge_pwm_pkg.sv
package hbridge_pwm_pkg;

  // Strobes from the counter control to the datapath.
  typedef struct packed {
    logic load;    // capture new period/compare/rotation (counter wraps)
    logic clrPwm;  // next counter value is zero
    logic setPwm;  // next counter value equals the captured compare
  } hbStrobe_t;

  localparam logic [1:0] ROT_LEFT  = 2'd0;
  localparam logic [1:0] ROT_RIGHT = 2'd1;
  localparam logic [1:0] ROT_OFF   = 2'd3;

endpackage

// File: rtl/hbridge_pwm_ctrl.sv
module hbridge_pwm_ctrl
  import hbridge_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] shPeriod,
  input  logic [CNT_W-1:0] shCmp,
  output logic [CNT_W-1:0] cnt,
  output hbStrobe_t        strobe
);

  logic             wrap;
  logic [CNT_W-1:0] cntNext;

  assign wrap    = (cnt >= shPeriod);
  assign cntNext = wrap ? '0 : cnt + CNT_W'(1);

  always_comb begin
    strobe.load   = wrap;
    strobe.clrPwm = (cntNext == '0);
    strobe.setPwm = (cntNext == shCmp);
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cntNext;
  end

  // R1: counter never runs past the captured period
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    cnt <= shPeriod)
    else $error("counter beyond period");

  // R1: reaching the period restarts the count at zero
  p_wrap_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt >= shPeriod) |=> (cnt == '0))
    else $error("counter did not restart");

endmodule

// File: rtl/hbridge_pwm_dp.sv
module hbridge_pwm_dp
  import hbridge_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int Q_FRAC = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodMax,
  input  logic [CNT_W-1:0] periodScale,
  input  logic [CNT_W-1:0] dutyCmd,
  input  logic             activeHigh,
  input  logic [1:0]       rotation,
  input  hbStrobe_t        strobe,
  output logic [CNT_W-1:0] shPeriod,
  output logic [CNT_W-1:0] shCmp,
  output logic             pwmQ,
  output logic [1:0]       gateHigh,
  output logic [1:0]       gateLow
);

  localparam int PROD_W = 2 * CNT_W;
  localparam logic [CNT_W-1:0] Q_ONE = CNT_W'((1 << Q_FRAC) - 1);
  localparam int N_LEG = 2;

  logic [PROD_W-1:0] periodProd;
  logic [PROD_W-1:0] cmpProd;
  logic [CNT_W-1:0]  newPeriod;
  logic [CNT_W-1:0]  dutyOp;
  logic [CNT_W-1:0]  newCmp;
  logic [1:0]        shRot;

  // Fixed-point scaling of period and compare
  assign periodProd = PROD_W'(periodMax) * PROD_W'(periodScale);
  assign newPeriod  = CNT_W'(periodProd >> Q_FRAC);
  assign dutyOp     = activeHigh ? (Q_ONE - dutyCmd) : dutyCmd;
  assign cmpProd    = PROD_W'(newPeriod) * PROD_W'(dutyOp);
  assign newCmp     = CNT_W'(cmpProd >> Q_FRAC);

  // Shadow registers, captured at the carrier restart
  always_ff @(posedge clk) begin
    if (rst) begin
      shPeriod <= '0;
      shCmp    <= '0;
      shRot    <= ROT_OFF;
    end else if (strobe.load) begin
      shPeriod <= newPeriod;
      shCmp    <= newCmp;
      shRot    <= rotation;
    end
  end

  // PWM level: zero event wins over compare event
  always_ff @(posedge clk) begin
    if (rst)                pwmQ <= 1'b0;
    else if (strobe.clrPwm) pwmQ <= 1'b0;
    else if (strobe.setPwm) pwmQ <= 1'b1;
  end

  // Leg steering: leg g switches when the rotation selects it,
  // its low side conducts when the other leg switches.
  for (genvar g = 0; g < N_LEG; g++) begin : g_leg
    localparam logic [1:0] OWN_CODE   = 2'(g);
    localparam logic [1:0] OTHER_CODE = 2'(N_LEG - 1 - g);
    assign gateHigh[g] = pwmQ & (shRot == OWN_CODE);
    assign gateLow[g]  = (shRot == OTHER_CODE);
  end

  // R10: no leg ever has both switches on
  p_no_shoot_r10: assert property (@(posedge clk) disable iff (rst)
    !(gateHigh[0] && gateLow[0]) && !(gateHigh[1] && gateLow[1]))
    else $error("shoot-through on a leg");

  // R7: captured values change only on a load strobe
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !strobe.load |=> $stable(shPeriod) && $stable(shCmp) && $stable(shRot))
    else $error("shadow changed mid-cycle");

  // R6: off codes leave every gate low
  p_off_low_r6: assert property (@(posedge clk) disable iff (rst)
    shRot[1] |-> (gateHigh == 2'b00) && (gateLow == 2'b00))
    else $error("gate on in off state");

  // R8: one edge of reset leaves all gates low
  p_reset_low_r8: assert property (@(posedge clk)
    $past(rst) |-> (gateHigh == 2'b00) && (gateLow == 2'b00))
    else $error("gate on after reset");

endmodule

// File: rtl/hbridge_pwm.sv
module hbridge_pwm
  import hbridge_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int Q_FRAC = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodMax,
  input  logic [CNT_W-1:0] periodScale,
  input  logic [CNT_W-1:0] dutyCmd,
  input  logic             activeHigh,
  input  logic [1:0]       rotation,
  output logic             leftHigh,
  output logic             leftLow,
  output logic             rightHigh,
  output logic             rightLow
);

  hbStrobe_t        strobe;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] shPeriod;
  logic [CNT_W-1:0] shCmp;
  logic             pwmQ;
  logic [1:0]       gateHigh;
  logic [1:0]       gateLow;

  hbridge_pwm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .shPeriod (shPeriod),
    .shCmp    (shCmp),
    .cnt      (cnt),
    .strobe   (strobe)
  );

  hbridge_pwm_dp #(.CNT_W(CNT_W), .Q_FRAC(Q_FRAC)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .periodMax   (periodMax),
    .periodScale (periodScale),
    .dutyCmd     (dutyCmd),
    .activeHigh  (activeHigh),
    .rotation    (rotation),
    .strobe      (strobe),
    .shPeriod    (shPeriod),
    .shCmp       (shCmp),
    .pwmQ        (pwmQ),
    .gateHigh    (gateHigh),
    .gateLow     (gateLow)
  );

  assign leftHigh  = gateHigh[0];
  assign leftLow   = gateLow[0];
  assign rightHigh = gateHigh[1];
  assign rightLow  = gateLow[1];

  // R3: count zero always sees the PWM low
  p_zero_low_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |-> !pwmQ)
    else $error("pwm high at count zero");

  // R3: reaching a non-zero compare drives the PWM high
  p_cmp_high_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt == shCmp) && (cnt != '0) |-> pwmQ)
    else $error("pwm low at compare");

endmodule

// File: tb/hbridge_pwm_tb.sv
module hbridge_pwm_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] periodMax = '0;
  logic [15:0] periodScale = '0;
  logic [15:0] dutyCmd = '0;
  logic        activeHigh = 1'b0;
  logic [1:0]  rotation = 2'd3;
  logic        leftHigh, leftLow, rightHigh, rightLow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hbridge_pwm u_dut (
    .clk(clk), .rst(rst), .periodMax(periodMax), .periodScale(periodScale),
    .dutyCmd(dutyCmd), .activeHigh(activeHigh), .rotation(rotation),
    .leftHigh(leftHigh), .leftLow(leftLow), .rightHigh(rightHigh), .rightLow(rightLow)
  );

  typedef struct packed {
    logic [15:0] pm;
    logic [15:0] sc;
    logic [15:0] duty;
    logic        ah;
    logic [1:0]  rot;
    int          eP;
    int          eLH;
    int          eLL;
    int          eRH;
    int          eRL;
  } vec_t;

  // Expected high counts over one window of P+1 cycles.
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'd80,  16'h4000, 16'h4000, 1'b0, 2'd0, 40, 21,  0,  0, 41}, // C=20
    '{16'd80,  16'h4000, 16'h2000, 1'b1, 2'd0, 40, 12,  0,  0, 41}, // R2: C=29
    '{16'd100, 16'h6000, 16'h2000, 1'b0, 2'd1, 75,  0, 76, 58,  0}, // C=18
    '{16'd60,  16'h7FFF, 16'h6000, 1'b1, 2'd1, 59,  0, 60, 46,  0}, // R2: C=14
    '{16'd80,  16'h4000, 16'h4000, 1'b0, 2'd2, 40,  0,  0,  0,  0}, // R6
    '{16'd80,  16'h4000, 16'h4000, 1'b0, 2'd3, 40,  0,  0,  0,  0}, // R6
    '{16'd80,  16'h4000, 16'h0000, 1'b0, 2'd0, 40,  0,  0,  0, 41}, // R9: C=0
    '{16'd80,  16'h4000, 16'h7FFF, 1'b1, 2'd1, 40,  0, 41,  0,  0}, // R9: C=0 via R2
    '{16'd80,  16'h4000, 16'hFFFF, 1'b0, 2'd0, 40,  0,  0,  0, 41}, // R9: C=79>P
    '{16'd80,  16'h4000, 16'h8000, 1'b0, 2'd0, 40,  1,  0,  0, 41}  // C=P
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    periodMax = v.pm; periodScale = v.sc; dutyCmd = v.duty;
    activeHigh = v.ah; rotation = v.rot;
  endtask

  task automatic window(input int len, output int hLH, output int hLL,
                        output int hRH, output int hRL, output int shoot);
    hLH = 0; hLL = 0; hRH = 0; hRL = 0; shoot = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      hLH += int'(leftHigh); hLL += int'(leftLow);
      hRH += int'(rightHigh); hRL += int'(rightLow);
      if ((leftHigh && leftLow) || (rightHigh && rightLow)) shoot++;
    end
  endtask

  // Rise-to-rise distance of the selected high-side output.
  task automatic riseGap(input bit right, output int gap);
    logic prev, cur;
    int n;
    gap = -1;
    prev = 1'b1;
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      cur = right ? rightHigh : leftHigh;
      if (!prev && cur) begin
        if (n > 0) begin gap = n; break; end
        n = 1;
      end else if (n > 0) n++;
      prev = cur;
    end
  endtask

  function automatic string tagFor(input vec_t v, input bit isPwmLeg, input int exp);
    if (v.rot[1]) return "R6";
    if (isPwmLeg && exp == 0) return "R9";
    if (isPwmLeg && v.ah) return "R2";
    if (isPwmLeg) return "R3";
    return (v.rot == 2'd0) ? "R4" : "R5";
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int hLH, hLL, hRH, hRL, shoot, gap, bad, n;
    repeat (3) @(negedge clk);
    // R8: outputs low while reset held
    chk("R8", "reset gates", {leftHigh, leftLow, rightHigh, rightLow}, 0);
    rst = 1'b0;

    foreach (VECS[k]) begin
      drive(VECS[k]);
      repeat (250) @(negedge clk);
      window(VECS[k].eP + 1, hLH, hLL, hRH, hRL, shoot);
      chk(tagFor(VECS[k], VECS[k].rot == 2'd0, VECS[k].eLH), $sformatf("v%0d leftHigh", k), hLH, VECS[k].eLH);
      chk(tagFor(VECS[k], 1'b0, VECS[k].eLL), $sformatf("v%0d leftLow", k), hLL, VECS[k].eLL);
      chk(tagFor(VECS[k], VECS[k].rot == 2'd1, VECS[k].eRH), $sformatf("v%0d rightHigh", k), hRH, VECS[k].eRH);
      chk(tagFor(VECS[k], 1'b0, VECS[k].eRL), $sformatf("v%0d rightLow", k), hRL, VECS[k].eRL);
      chk("R10", $sformatf("v%0d shoot-through cycles", k), shoot, 0);
      if ((VECS[k].eLH > 0) || (VECS[k].eRH > 0)) begin
        riseGap(VECS[k].rot == 2'd1, gap);
        chk("R1", $sformatf("v%0d carrier length", k), gap, VECS[k].eP + 1);
      end
    end

    // R7: rotation change mid-cycle waits for the wrap. P=200, C=100.
    periodMax = 16'd400; periodScale = 16'h4000; dutyCmd = 16'h4000;
    activeHigh = 1'b0; rotation = 2'd0;
    repeat (500) @(negedge clk);
    n = 0;
    while (!leftHigh && n < 1000) begin @(negedge clk); n++; end
    while (leftHigh && n < 2000) begin @(negedge clk); n++; end
    // counter is 0 at this sample
    repeat (20) @(negedge clk);
    rotation = 2'd1;
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (leftLow || !rightLow) bad++;
    end
    chk("R7", "old diagonal held until wrap", bad, 0);
    repeat (100) @(negedge clk);
    chk("R7", "new diagonal after wrap", {leftLow, rightLow}, 2'b10);

    // R8: reset mid-run clears gates and counter. P=40, C=20.
    drive(VECS[0]);
    repeat (300) @(negedge clk);
    while (!leftHigh) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "gates during reset", {leftHigh, leftLow, rightHigh, rightLow}, 0);
    rst = 1'b0;
    n = 0;
    while (!leftHigh && n < 500) begin @(negedge clk); n++; end
    chk("R8", "cycles from release to first PWM rise", n, 21);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule